// File: doc/BRIEF.md
# Serial Link Boot Loader

This block decides how a small processor node leaves reset. A strap input picks between two start modes. With the strap high, the core is told to start near the top of memory and the links are never read. With the strap low, the loader waits for the first byte on any of its byte-wide link receivers. That byte either gives the size of a code image or selects a single memory inspect or modify request.

A code image is copied byte by byte into the bottom of memory. One cycle after the last byte is written, the core receives a start strobe together with the start address. An inspect request (peek) reads one word and sends it back as bytes on the link that asked for it. A modify request (poke) writes one word. After a peek or a poke the loader waits for a new first byte. Once the core has been started, the loader stays silent until the next reset.

The receive side and the reply side are valid/ready byte streams. A byte moves on a receive link only in a cycle where both its valid and ready are high. The sender must hold the byte steady until that cycle. A reply byte moves when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the loader holds the byte and its link index unchanged. The memory port is plain: writes take effect at the clock edge, and read data comes back one cycle after `mem_re`.

Top module: `link_boot_loader`

## Requirements
- R1: With `boot_rom_strap` high at reset release, `start_pulse` rises in the second cycle after release with `start_addr` equal to the memory byte size minus two, and no receive byte is ever accepted.
- R2: With the strap low, the first byte accepted on any link is the command byte. When several links offer a first byte in the same cycle, the lowest-numbered link wins and becomes the active link.
- R3: A command byte of 2 to 255 is a code length L. The next L bytes from the active link are written to byte addresses 0 to L-1 in arrival order. Each write uses word address = byte address / (WORD_W/8) and enables only lane byte address mod (WORD_W/8), with byte lane k holding bits 8k+7:8k.
- R4: `start_pulse` is high for exactly one cycle, the cycle after the last code byte is written, with `start_addr` 0. From then on every `rx_ready` stays low, and `mem_we`, `mem_re` and `tx_valid` stay low.
- R5: A command byte of 0 is a peek. One word address follows, least significant byte first. The loader issues one read of that word and sends the word back as WORD_W/8 bytes, least significant first, with `tx_link` equal to the requesting link.
- R6: A command byte of 1 is a poke. A word address follows, then a data word, both least significant byte first. The loader then makes one write with all byte lanes enabled.
- R7: After a peek reply or a poke write completes, the next byte on any link is again treated as a command byte.
- R8: While a transaction is in progress, the other links see `rx_ready` high. Their bytes are accepted and discarded, and cause no write, no read and no reply.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_link` hold their values.
- R10: During a peek, from the read until the last reply byte is taken, `rx_ready` of the active link is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_rom_strap | input | 1 | High: start from memory top without link traffic |
| rx_valid | input | NUM_LINKS | Per-link receive byte valid |
| rx_data | input | 8*NUM_LINKS | Per-link receive byte; link i uses bits 8i+7:8i |
| rx_ready | output | NUM_LINKS | Per-link receive ready |
| tx_valid | output | 1 | Reply byte valid |
| tx_ready | input | 1 | Reply byte ready |
| tx_data | output | 8 | Reply byte |
| tx_link | output | max(1,log2 NUM_LINKS) | Link the reply byte belongs to |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | WORD_W/8 | Byte lane enables for the write |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | WORD_W | Write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | WORD_W | Read data, valid one cycle after mem_re |
| start_pulse | output | 1 | One-cycle core start strobe |
| start_addr | output | MEM_AW+log2(WORD_W/8) | Byte address where the core starts |

## Verification
A code byte or a poke is written on the same clock edge that accepts it, or one edge after the last poke data byte. The start strobe follows the last code write by exactly one cycle. With the strap high, the strobe arrives in the second cycle after reset release. A peek's first reply byte is valid two edges after the edge that accepts the last address byte. The bench stamps every write, strobe and reply byte with a cycle count that restarts at reset. It compares those stamps with the expected offsets and reads memory only from its own model after the due cycle. Back-pressure and dropped-link checks sample `tx_valid`, `tx_data` and `rx_ready` between clock edges, while the loader sits in the waiting state under test.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

  typedef enum logic [3:0] {
    ST_STRAP,
    ST_HUNT,
    ST_LOAD,
    ST_PK_ADDR,
    ST_PK_READ,
    ST_PK_CAP,
    ST_PK_SEND,
    ST_PO_ADDR,
    ST_PO_DATA,
    ST_PO_WRITE,
    ST_LAUNCH,
    ST_RUN
  } ldr_state_e;

  localparam logic [7:0] CMD_PEEK = 8'd0;
  localparam logic [7:0] CMD_POKE = 8'd1;

endpackage

// File: rtl/lbl_link_sel.sv
module lbl_link_sel #(
  parameter int NUM_LINKS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_LINKS-1:0]   rx_valid,
  input  logic [NUM_LINKS*8-1:0] rx_data,
  input  logic                   hunt,
  input  logic [IDX_W-1:0]       act_idx,
  input  logic                   act_take,
  input  logic                   drop_rest,
  output logic [NUM_LINKS-1:0]   rx_ready,
  output logic                   sel_valid,
  output logic [7:0]             sel_data,
  output logic [IDX_W-1:0]       win_idx
);

  logic             win_any;
  logic [IDX_W-1:0] mux_idx;
  logic [7:0]       lane_byte [NUM_LINKS];

  // lowest-numbered valid link wins the hunt
  always_comb begin
    win_idx = '0;
    win_any = 1'b0;
    for (int i = NUM_LINKS - 1; i >= 0; i--) begin
      if (rx_valid[i]) begin
        win_idx = IDX_W'(i);
        win_any = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_lane
    assign lane_byte[g] = rx_data[g*8 +: 8];
    assign rx_ready[g]  = hunt ? (win_any && (win_idx == IDX_W'(g)))
                               : ((act_idx == IDX_W'(g)) ? act_take : drop_rest);
  end

  assign mux_idx   = hunt ? win_idx : act_idx;
  assign sel_valid = hunt ? win_any : rx_valid[mux_idx];
  assign sel_data  = lane_byte[mux_idx];

endmodule

// File: rtl/lbl_word_asm.sv
module lbl_word_asm #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [7:0]        byte_in,
  output logic [WORD_W-1:0] word_out
);

  // low byte arrives first, so new bytes enter at the top and slide down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out <= '0;
    end else if (shift_en) begin
      word_out <= {byte_in, word_out[WORD_W-1:8]};
    end
  end

endmodule

// File: rtl/lbl_tx_ser.sv
module lbl_tx_ser #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              done
);

  localparam int BYTES = WORD_W / 8;
  localparam int CNT_W = $clog2(BYTES);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  sent;
  logic              busy;
  logic              last;

  assign last     = (sent == CNT_W'(BYTES - 1));
  assign tx_valid = busy;
  assign tx_data  = shreg[7:0];
  assign done     = busy && tx_ready && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sent  <= '0;
      busy  <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        shreg <= load_word;
        sent  <= '0;
        busy  <= 1'b1;
      end
    end else if (tx_ready) begin
      shreg <= {8'h00, shreg[WORD_W-1:8]};
      sent  <= sent + CNT_W'(1);
      if (last) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/link_boot_loader.sv
module link_boot_loader #(
  parameter int NUM_LINKS = 4,
  parameter int WORD_W    = 32,   // 16 or 32
  parameter int MEM_AW    = 10,   // word address bits, not above WORD_W
  localparam int BYTES    = WORD_W / 8,
  localparam int LANE_W   = $clog2(BYTES),
  localparam int IDX_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int BADDR_W  = MEM_AW + LANE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boot_rom_strap,
  input  logic [NUM_LINKS-1:0]   rx_valid,
  input  logic [NUM_LINKS*8-1:0] rx_data,
  output logic [NUM_LINKS-1:0]   rx_ready,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic [IDX_W-1:0]       tx_link,
  output logic                   mem_we,
  output logic [BYTES-1:0]       mem_be,
  output logic [MEM_AW-1:0]      mem_addr,
  output logic [WORD_W-1:0]      mem_wdata,
  output logic                   mem_re,
  input  logic [WORD_W-1:0]      mem_rdata,
  output logic                   start_pulse,
  output logic [BADDR_W-1:0]     start_addr
);

  import lbl_pkg::*;

  // two bytes below the top of the byte address space
  localparam logic [BADDR_W-1:0] ROM_START = ~BADDR_W'(1);

  ldr_state_e         state;
  logic [IDX_W-1:0]   act_idx;
  logic [7:0]         len_m1;
  logic [7:0]         cnt;
  logic [MEM_AW-1:0]  addr_q;
  logic [BADDR_W-1:0] start_q;

  logic              hunt, act_take, drop_rest, take;
  logic              sel_valid;
  logic [7:0]        sel_data;
  logic [IDX_W-1:0]  win_idx;
  logic              asm_shift;
  logic [WORD_W-1:0] asm_word;
  logic              word_last;
  logic              ser_done;

  assign hunt      = (state == ST_HUNT);
  assign act_take  = (state == ST_LOAD) || (state == ST_PK_ADDR) ||
                     (state == ST_PO_ADDR) || (state == ST_PO_DATA);
  assign drop_rest = act_take || (state == ST_PK_READ) || (state == ST_PK_CAP) ||
                     (state == ST_PK_SEND) || (state == ST_PO_WRITE);
  assign take      = sel_valid && (hunt || act_take);
  assign asm_shift = take && ((state == ST_PK_ADDR) || (state == ST_PO_ADDR) ||
                              (state == ST_PO_DATA));
  assign word_last = (cnt == 8'(BYTES - 1));

  lbl_link_sel #(
    .NUM_LINKS (NUM_LINKS),
    .IDX_W     (IDX_W)
  ) u_sel (
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .hunt      (hunt),
    .act_idx   (act_idx),
    .act_take  (act_take),
    .drop_rest (drop_rest),
    .rx_ready  (rx_ready),
    .sel_valid (sel_valid),
    .sel_data  (sel_data),
    .win_idx   (win_idx)
  );

  lbl_word_asm #(
    .WORD_W   (WORD_W)
  ) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (asm_shift),
    .byte_in  (sel_data),
    .word_out (asm_word)
  );

  lbl_tx_ser #(
    .WORD_W    (WORD_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (state == ST_PK_CAP),
    .load_word (mem_rdata),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .done      (ser_done)
  );

  // memory port
  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_be    = '0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_LOAD: begin
        mem_we    = take;
        mem_addr  = MEM_AW'(cnt >> LANE_W);
        mem_be    = BYTES'(1) << cnt[LANE_W-1:0];
        mem_wdata = {BYTES{sel_data}};
      end
      ST_PK_READ: begin
        mem_re   = 1'b1;
        mem_addr = asm_word[MEM_AW-1:0];
      end
      ST_PO_WRITE: begin
        mem_we    = 1'b1;
        mem_addr  = addr_q;
        mem_be    = '1;
        mem_wdata = asm_word;
      end
      default: ;
    endcase
  end

  assign tx_link     = act_idx;
  assign start_pulse = (state == ST_LAUNCH);
  assign start_addr  = start_q;

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_STRAP;
      act_idx <= '0;
      len_m1  <= '0;
      cnt     <= '0;
      addr_q  <= '0;
      start_q <= '0;
    end else begin
      unique case (state)
        ST_STRAP: begin
          if (boot_rom_strap) begin
            start_q <= ROM_START;
            state   <= ST_LAUNCH;
          end else begin
            state <= ST_HUNT;
          end
        end
        ST_HUNT: begin
          if (take) begin
            act_idx <= win_idx;
            cnt     <= '0;
            if (sel_data == CMD_PEEK) begin
              state <= ST_PK_ADDR;
            end else if (sel_data == CMD_POKE) begin
              state <= ST_PO_ADDR;
            end else begin
              len_m1 <= sel_data - 8'd1;
              state  <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (take) begin
            if (cnt == len_m1) begin
              start_q <= '0;
              state   <= ST_LAUNCH;
            end else begin
              cnt <= cnt + 8'd1;
            end
          end
        end
        ST_PK_ADDR: begin
          if (take) begin
            if (word_last) state <= ST_PK_READ;
            else           cnt   <= cnt + 8'd1;
          end
        end
        ST_PK_READ: state <= ST_PK_CAP;
        ST_PK_CAP:  state <= ST_PK_SEND;
        ST_PK_SEND: begin
          if (ser_done) state <= ST_HUNT;
        end
        ST_PO_ADDR: begin
          if (take) begin
            if (word_last) begin
              cnt   <= '0;
              state <= ST_PO_DATA;
            end else begin
              cnt <= cnt + 8'd1;
            end
          end
        end
        ST_PO_DATA: begin
          if (take) begin
            // the assembler still holds the full address before its first data shift
            if (cnt == 8'd0) addr_q <= asm_word[MEM_AW-1:0];
            if (word_last) state <= ST_PO_WRITE;
            else           cnt   <= cnt + 8'd1;
          end
        end
        ST_PO_WRITE: state <= ST_HUNT;
        ST_LAUNCH:   state <= ST_RUN;
        ST_RUN:      state <= ST_RUN;
        default:     state <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/lbl_chk.sv
module lbl_chk #(
  parameter int NUM_LINKS = 4,
  parameter int WORD_W    = 32,
  parameter int MEM_AW    = 10,
  localparam int LANE_W   = $clog2(WORD_W / 8),
  localparam int IDX_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int BADDR_W  = MEM_AW + LANE_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 boot_rom_strap,
  input logic [NUM_LINKS-1:0] rx_ready,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [7:0]           tx_data,
  input logic [IDX_W-1:0]     tx_link,
  input logic                 mem_we,
  input logic                 mem_re,
  input logic                 start_pulse,
  input logic [BADDR_W-1:0]   start_addr
);

  localparam logic [BADDR_W-1:0] ROM_START = ~BADDR_W'(1);

  logic launched;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           launched <= 1'b0;
    else if (start_pulse) launched <= 1'b1;
  end

  p_rom_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse && boot_rom_strap |-> start_addr == ROM_START);

  p_low_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse && !boot_rom_strap |-> start_addr == '0);

  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_silent_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launched |-> (rx_ready == '0) && !mem_we && !mem_re && !tx_valid && !start_pulse);

  p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  p_no_rw_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_reply_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_link));

endmodule

bind link_boot_loader lbl_chk #(
  .NUM_LINKS (NUM_LINKS),
  .WORD_W    (WORD_W),
  .MEM_AW    (MEM_AW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .boot_rom_strap (boot_rom_strap),
  .rx_ready       (rx_ready),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .tx_data        (tx_data),
  .tx_link        (tx_link),
  .mem_we         (mem_we),
  .mem_re         (mem_re),
  .start_pulse    (start_pulse),
  .start_addr     (start_addr)
);

// File: tb/link_boot_loader_bench.sv
`timescale 1ns/1ps
module link_boot_loader_bench;

  localparam int NL = 4;
  localparam int WW = 32;
  localparam int AW = 6;
  localparam int NWORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strap = 1'b0;
  logic [NL-1:0] rx_valid = '0;
  logic [NL*8-1:0] rx_data = '0;
  logic [NL-1:0] rx_ready;
  logic          tx_valid;
  logic          tx_ready = 1'b1;
  logic [7:0]    tx_data;
  logic [1:0]    tx_link;
  logic          mem_we;
  logic [3:0]    mem_be;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic          mem_re;
  logic [WW-1:0] mem_rdata;
  logic          start_pulse;
  logic [7:0]    start_addr;

  always #2.5 clk = ~clk;

  link_boot_loader #(.NUM_LINKS(NL), .WORD_W(WW), .MEM_AW(AW)) u_link_boot_loader (
    .clk(clk), .rst_n(rst_n), .boot_rom_strap(strap),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_link(tx_link),
    .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata),
    .start_pulse(start_pulse), .start_addr(start_addr)
  );

  function automatic logic [31:0] memv(input int i);
    return 32'h5A00_0000 + i * 32'h0001_0203;
  endfunction

  // memory model and monitors
  logic [31:0] mem [NWORDS];
  int cyc, we_cnt, re_cnt, last_we_cyc, st_cnt, st_cyc, tx_cnt;
  logic [7:0] st_addr;
  logic [7:0] txb [64];
  logic [1:0] txl [64];
  int hs_cnt [NL];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= memv(i);
      mem_rdata <= '0;
    end else begin
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (mem_we) begin we_cnt <= we_cnt + 1; last_we_cyc <= cyc; end
      if (mem_re) re_cnt <= re_cnt + 1;
      if (start_pulse) begin st_cnt <= st_cnt + 1; st_cyc <= cyc; st_addr <= start_addr; end
      if (tx_valid && tx_ready) begin
        txb[tx_cnt[5:0]] <= tx_data;
        txl[tx_cnt[5:0]] <= tx_link;
        tx_cnt <= tx_cnt + 1;
      end
      for (int l = 0; l < NL; l++)
        if (rx_valid[l] && rx_ready[l]) hs_cnt[l] <= hs_cnt[l] + 1;
    end
  end

  int vectors = 0;
  int fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; rx_valid = '0; tx_ready = 1'b1;
    repeat (2) @(negedge clk);
    we_cnt = 0; re_cnt = 0; last_we_cyc = 0; st_cnt = 0; st_cyc = 0; tx_cnt = 0;
    for (int l = 0; l < NL; l++) hs_cnt[l] = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_byte(input int l, input logic [7:0] b);
    @(negedge clk);
    rx_valid[l] = 1'b1; rx_data[l*8 +: 8] = b;
    #1;
    while (!rx_ready[l]) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    rx_valid[l] = 1'b0;
  endtask

  task automatic send_word(input int l, input logic [31:0] w);
    for (int b = 0; b < 4; b++) send_byte(l, w[b*8 +: 8]);
  endtask

  task automatic wait_tx(input int n);
    int guard = 0;
    while (tx_cnt < n && guard < 200) begin @(negedge clk); guard++; end
  endtask

  task automatic t_rom_boot;
    do_reset(1'b1);
    rx_valid[0] = 1'b1; rx_data[7:0] = 8'h05;
    repeat (6) @(negedge clk);
    check("R1 start count", st_cnt, 1);
    check("R1 start cycle", st_cyc, 1);
    check("R1 start addr", {24'h0, st_addr}, 32'hFE);
    check("R1 no rx accepted", hs_cnt[0], 0);
    check("R1 rx_ready low", {28'h0, rx_ready}, 0);
    rx_valid = '0;
  endtask

  task automatic t_poke_peek;
    do_reset(1'b0);
    send_byte(1, 8'd1); send_word(1, 32'd5); send_word(1, 32'hA5C3_1E07);
    repeat (2) @(negedge clk);
    check("R6 poke data", mem[5], 32'hA5C3_1E07);
    check("R6 one write", we_cnt, 1);
    // R7: next command is honoured on another link
    send_byte(3, 8'd1); send_word(3, 32'd9); send_word(3, 32'h0BAD_F00D);
    repeat (2) @(negedge clk);
    check("R7 second poke", mem[9], 32'h0BAD_F00D);
    send_byte(2, 8'd0); send_word(2, 32'd5);
    wait_tx(4);
    check("R5 reply bytes", {txb[3], txb[2], txb[1], txb[0]}, 32'hA5C3_1E07);
    check("R5 reply link", {30'h0, txl[3]}, 2);
    check("R5 one read", re_cnt, 1);
    check("R4 no start yet", st_cnt, 0);
  endtask

  task automatic t_backpressure;
    do_reset(1'b0);
    tx_ready = 1'b0;
    send_byte(0, 8'd0); send_word(0, 32'd3);
    repeat (3) @(negedge clk);
    check("R9 valid held", {31'h0, tx_valid}, 1);
    check("R9 first byte", {24'h0, tx_data}, {24'h0, memv(3)[7:0]});
    rx_valid[0] = 1'b1; rx_data[7:0] = 8'h01;
    #1;
    check("R10 active link stalled", {31'h0, rx_ready[0]}, 0);
    check("R8 other link open", {31'h0, rx_ready[3]}, 1);
    repeat (3) @(negedge clk);
    check("R9 byte stable", {24'h0, tx_data}, {24'h0, memv(3)[7:0]});
    check("R10 no extra take", hs_cnt[0], 5);
    rx_valid[0] = 1'b0;
    tx_ready = 1'b1;
    wait_tx(4);
    check("R5 reply after stall", {txb[3], txb[2], txb[1], txb[0]}, memv(3));
  endtask

  task automatic t_other_links;
    do_reset(1'b0);
    // R2: links 0 and 3 offer a command in the same cycle, link 0 wins
    fork
      send_byte(0, 8'd1);
      send_byte(3, 8'd0);
    join
    fork
      begin send_word(0, 32'd12); send_word(0, 32'h1234_5678); end
      begin send_byte(2, 8'd1); send_byte(2, 8'd7); send_byte(2, 8'd0); end
    join
    repeat (3) @(negedge clk);
    check("R2 poke from link 0", mem[12], 32'h1234_5678);
    check("R8 single write", we_cnt, 1);
    check("R8 no reply", tx_cnt, 0);
    check("R8 link 2 drained", hs_cnt[2], 3);
    check("R8 link 3 drained", hs_cnt[3], 1);
    check("R8 word 7 untouched", mem[7], memv(7));
    send_byte(1, 8'd0); send_word(1, 32'd12);
    wait_tx(4);
    check("R7 peek after ignored traffic", {txb[3], txb[2], txb[1], txb[0]}, 32'h1234_5678);
  endtask

  task automatic t_boot_long;
    logic [31:0] e2;
    do_reset(1'b0);
    send_byte(3, 8'd10);
    for (int i = 0; i < 10; i++) send_byte(3, 8'h40 + 8'(i));
    repeat (3) @(negedge clk);
    e2 = {memv(2)[31:16], 16'h4948};
    check("R3 word 0", mem[0], 32'h4342_4140);
    check("R3 word 1", mem[1], 32'h4746_4544);
    check("R3 partial word 2", mem[2], e2);
    check("R3 write count", we_cnt, 10);
    check("R4 start count", st_cnt, 1);
    check("R4 start addr", {24'h0, st_addr}, 0);
    check("R4 start one cycle after write", st_cyc, last_we_cyc + 1);
    rx_valid[0] = 1'b1; rx_data[7:0] = 8'h01;
    repeat (3) @(negedge clk);
    #1;
    check("R4 links closed", {28'h0, rx_ready}, 0);
    check("R4 no later writes", we_cnt, 10);
    rx_valid[0] = 1'b0;
  endtask

  task automatic t_boot_short;
    do_reset(1'b0);
    send_byte(2, 8'd2);
    send_byte(2, 8'hC1); send_byte(2, 8'hD2);
    repeat (3) @(negedge clk);
    check("R3 length two", mem[0], {memv(0)[31:16], 16'hD2C1});
    check("R4 short start", st_cnt, 1);
    check("R3 word 1 untouched", mem[1], memv(1));
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_rom_boot();
    t_poke_peek();
    t_backpressure();
    t_other_links();
    t_boot_long();
    t_boot_short();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule